// File: doc/BRIEF.md
# Last-Outcome Branch Predictor with Return-Address Stack

This block gives a dual-issue fetch front end its direction and return-target guesses. A direction table holds one bit per instruction slot of the instruction cache. The lookup port takes a slot index and a branch kind. One cycle later the block answers with a taken or not-taken prediction. For a conditional branch, that prediction repeats the last resolved outcome stored for the slot. When a branch resolves, the update port writes the real outcome back into the table.

Return targets come from a small circular stack. A call pushes its return address and a return pops it. The popped address, with a valid flag, is the predicted fetch target. Once a stack is full, a further push overwrites the oldest entry, so the newest addresses always survive.

When a resolved outcome disagrees with the table, or a resolved return target disagrees with the last popped prediction, the block raises a one-cycle redirect. The redirect carries the penalty in cycles, so the front end can time its recovery.

Top module: `bp_front_predictor`

## Requirements
- R1: After reset every table entry reads not-taken, the stack is empty, and `pred_valid`, `redirect` and `ret_valid` are 0.
- R2: A lookup of kind conditional (`lk_kind`=1) sets `pred_valid` in the next cycle. In that cycle, `pred_taken` equals the bit stored for `lk_idx`.
- R3: An update writes `up_taken` into entry `up_idx` only. Later lookups of that index return it, and other indices keep their values.
- R4: When a lookup and an update hit the same index in one cycle, the lookup returns the value from before the update. The new value is seen from the next cycle on.
- R5: Kinds call (2) and return (3) always predict taken. Kind none (0) always predicts not-taken, whatever the table holds.
- R6: Pops return pushed addresses in last-in first-out order. `ret_target` and `ret_valid`=1 appear in the cycle after the pop and hold until the next pop.
- R7: A push to a stack holding four entries drops the oldest entry. The four newest addresses stay poppable.
- R8: A pop from an empty stack gives `ret_valid`=0 and `ret_target`=0.
- R9: An update whose outcome differs from the stored bit gives `redirect`=1 with `redirect_pen`=4 in the next cycle. An update that agrees gives no redirect.
- R10: A return check (`ret_chk_valid`) gives `redirect`=1 with `redirect_pen`=5 in the next cycle in two cases: the held prediction is invalid, or its target differs from `ret_chk_addr`. This penalty wins over a direction miss in the same cycle.
- R11: A push and a pop in the same cycle return the old top and leave the pushed address as the new top. The stack depth stays the same, and an empty stack becomes one entry deep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_idx | input | 11 | Instruction-slot index for lookup |
| lk_kind | input | 2 | 0 none, 1 conditional, 2 call, 3 return |
| pred_valid | output | 1 | Prediction valid (one cycle after lookup) |
| pred_taken | output | 1 | Predicted direction |
| up_valid | input | 1 | Resolved branch update |
| up_idx | input | 11 | Slot index of resolved branch |
| up_taken | input | 1 | Actual outcome |
| push | input | 1 | Push return address |
| push_addr | input | 32 | Return address to push |
| pop | input | 1 | Pop predicted return target |
| ret_valid | output | 1 | Popped target is valid |
| ret_target | output | 32 | Predicted return target |
| ret_chk_valid | input | 1 | A return resolved |
| ret_chk_addr | input | 32 | Actual return target |
| redirect | output | 1 | Misprediction redirect pulse |
| redirect_pen | output | 3 | Penalty cycles of the redirect |

## Verification
The assertions take for granted that `lk_kind` is always one of the four defined codes. They also take for granted that a return check refers to the target most recently popped. In the stack, they rely on the push and pop strobes being the only things that move the pointer.

The stimulus drives every input one time unit after a rising edge. It issues return checks only after the matching pop has produced its held prediction. The cases that need two inputs in one cycle, the same-index lookup and update and the paired push and pop, are driven together deliberately.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_COND = 2'd1,
    KIND_CALL = 2'd2,
    KIND_RET  = 2'd3
  } bp_kind_e;
endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  output logic             wr_miss
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= '0;
      rd_bit <= 1'b0;
    end else begin
      rd_bit <= hist[rd_idx];
      if (wr_en) hist[wr_idx] <= wr_bit;
    end
  end

  assign wr_miss = wr_en && (hist[wr_idx] != wr_bit);

  // R3: a resolved outcome is stored at its index
  a_r3_update_stored: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> hist[$past(wr_idx)] == $past(wr_bit));
endmodule

// File: rtl/bp_ret_stack.sv
module bp_ret_stack #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic              ret_valid,
  output logic [ADDR_W-1:0] ret_target
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  top;
  logic [CNT_W-1:0]  cnt;
  logic [PTR_W-1:0]  top_nx;

  assign top_nx = top + 1'b1;

  always_ff @(posedge clk) begin
    if (push && !pop) slots[top_nx] <= push_addr;
    else if (push && pop) slots[top] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top        <= '0;
      cnt        <= '0;
      ret_valid  <= 1'b0;
      ret_target <= '0;
    end else begin
      if (pop) begin
        ret_valid  <= (cnt != '0);
        ret_target <= (cnt != '0) ? slots[top] : '0;
      end
      if (push && !pop) begin
        top <= top_nx;
        cnt <= (cnt == FULL) ? FULL : cnt + 1'b1;
      end else if (push && pop) begin
        if (cnt == '0) cnt <= CNT_W'(1);
      end else if (pop && cnt != '0) begin
        top <= top - 1'b1;
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R7: depth never exceeds the number of slots
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  // R8: an empty pop gives no valid target
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt == '0) |=> !ret_valid);
  // R6: a pop with entries present gives a valid target
  a_r6_pop_valid: assert property (@(posedge clk) disable iff (rst)
    (pop && cnt != '0) |=> ret_valid);
  // R6: the held prediction stays put without a pop
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !pop |=> $stable(ret_target) && $stable(ret_valid));
endmodule

// File: rtl/bp_redirect.sv
module bp_redirect #(
  parameter int ADDR_W  = 32,
  parameter int PEN_W   = 3,
  parameter int DIR_PEN = 4,
  parameter int RET_PEN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_miss,
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              pred_ok,
  input  logic [ADDR_W-1:0] pred_addr,
  output logic              redirect,
  output logic [PEN_W-1:0]  redirect_pen
);
  logic ret_miss;
  assign ret_miss = chk_valid && (!pred_ok || pred_addr != chk_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect     <= 1'b0;
      redirect_pen <= '0;
    end else begin
      redirect     <= ret_miss || dir_miss;
      redirect_pen <= ret_miss ? PEN_W'(RET_PEN) :
                      dir_miss ? PEN_W'(DIR_PEN) : '0;
    end
  end

  // R9: no redirect without a miss source
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!dir_miss && !chk_valid) |=> !redirect);
  // R10: a return miss always costs the return penalty
  a_r10_ret_pen: assert property (@(posedge clk) disable iff (rst)
    ret_miss |=> redirect && redirect_pen == PEN_W'(RET_PEN));
endmodule

// File: rtl/bp_front_predictor.sv
module bp_front_predictor #(
  parameter int IDX_W     = 11,
  parameter int ADDR_W    = 32,
  parameter int RAS_DEPTH = 4,
  parameter int PEN_W     = 3,
  parameter int DIR_PEN   = 4,
  parameter int RET_PEN   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [1:0]        lk_kind,
  output logic              pred_valid,
  output logic              pred_taken,
  input  logic              up_valid,
  input  logic [IDX_W-1:0]  up_idx,
  input  logic              up_taken,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic              ret_valid,
  output logic [ADDR_W-1:0] ret_target,
  input  logic              ret_chk_valid,
  input  logic [ADDR_W-1:0] ret_chk_addr,
  output logic              redirect,
  output logic [PEN_W-1:0]  redirect_pen
);
  import bp_pkg::*;

  logic       tbl_bit;
  logic       tbl_miss;
  logic       lk_q;
  logic [1:0] kind_q;

  bp_dir_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_bit(tbl_bit),
    .wr_en(up_valid), .wr_idx(up_idx), .wr_bit(up_taken),
    .wr_miss(tbl_miss)
  );

  bp_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_stack (
    .clk(clk), .rst(rst),
    .push(push), .push_addr(push_addr), .pop(pop),
    .ret_valid(ret_valid), .ret_target(ret_target)
  );

  bp_redirect #(.ADDR_W(ADDR_W), .PEN_W(PEN_W), .DIR_PEN(DIR_PEN),
                .RET_PEN(RET_PEN)) u_redir (
    .clk(clk), .rst(rst),
    .dir_miss(tbl_miss), .chk_valid(ret_chk_valid), .chk_addr(ret_chk_addr),
    .pred_ok(ret_valid), .pred_addr(ret_target),
    .redirect(redirect), .redirect_pen(redirect_pen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_q   <= 1'b0;
      kind_q <= KIND_NONE;
    end else begin
      lk_q   <= lk_valid;
      kind_q <= lk_kind;
    end
  end

  assign pred_valid = lk_q;
  assign pred_taken = lk_q && ((kind_q == KIND_COND) ? tbl_bit :
                               (kind_q == KIND_CALL) || (kind_q == KIND_RET));

  // R5: returns and calls always predicted taken
  a_r5_jump_taken: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && (lk_kind == KIND_RET || lk_kind == KIND_CALL)) |=> pred_taken);
  // R5: kind none never predicted taken
  a_r5_none_not_taken: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_kind == KIND_NONE) |=> !pred_taken);
  // R2: a prediction follows each lookup
  a_r2_pred_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid);
endmodule

// File: tb/tb_bp_front_predictor.sv
module tb_bp_front_predictor;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [10:0] lk_idx;
  logic [1:0]  lk_kind;
  logic        pred_valid, pred_taken;
  logic        up_valid;
  logic [10:0] up_idx;
  logic        up_taken;
  logic        push;
  logic [31:0] push_addr;
  logic        pop;
  logic        ret_valid;
  logic [31:0] ret_target;
  logic        ret_chk_valid;
  logic [31:0] ret_chk_addr;
  logic        redirect;
  logic [2:0]  redirect_pen;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bp_front_predictor dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_kind(lk_kind),
    .pred_valid(pred_valid), .pred_taken(pred_taken),
    .up_valid(up_valid), .up_idx(up_idx), .up_taken(up_taken),
    .push(push), .push_addr(push_addr), .pop(pop),
    .ret_valid(ret_valid), .ret_target(ret_target),
    .ret_chk_valid(ret_chk_valid), .ret_chk_addr(ret_chk_addr),
    .redirect(redirect), .redirect_pen(redirect_pen)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_idx = '0; lk_kind = 2'd0;
    up_valid = 0; up_idx = '0; up_taken = 0;
    push = 0; push_addr = '0; pop = 0;
    ret_chk_valid = 0; ret_chk_addr = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic look(input int idx, input int kind, output logic tk);
    lk_valid = 1; lk_idx = 11'(idx); lk_kind = 2'(kind);
    step(); idle();
    tk = pred_taken;
  endtask

  task automatic upd(input int idx, input logic t);
    up_valid = 1; up_idx = 11'(idx); up_taken = t;
    step(); idle();
  endtask

  task automatic do_push(input logic [31:0] a);
    push = 1; push_addr = a; step(); idle();
  endtask

  task automatic do_pop();
    pop = 1; step(); idle();
  endtask

  task automatic t_reset();
    logic tk;
    idle(); rst = 1; step(); step(); rst = 0;
    check("R1 pred_valid", pred_valid, 0);
    check("R1 redirect", redirect, 0);
    check("R1 ret_valid", ret_valid, 0);
    look(5, 1, tk);    check("R1 entry 5", tk, 0);
    look(2047, 1, tk); check("R1 entry 2047", tk, 0);
    check("R2 pred_valid", pred_valid, 1);
  endtask

  task automatic t_update();
    logic tk;
    upd(10, 1);
    look(10, 1, tk); check("R3 written taken", tk, 1);
    look(11, 1, tk); check("R3 neighbour intact", tk, 0);
    upd(10, 0);
    look(10, 1, tk); check("R2 follows last outcome", tk, 0);
    upd(10, 1);
  endtask

  task automatic t_same_cycle();
    logic tk;
    lk_valid = 1; lk_idx = 11'd20; lk_kind = 2'd1;
    up_valid = 1; up_idx = 11'd20; up_taken = 1;
    step(); idle();
    check("R4 old value", pred_taken, 0);
    look(20, 1, tk); check("R4 new value next", tk, 1);
  endtask

  task automatic t_kinds();
    logic tk;
    look(40, 3, tk); check("R5 return taken", tk, 1);
    look(40, 2, tk); check("R5 call taken", tk, 1);
    look(10, 0, tk); check("R5 none not taken", tk, 0);
  endtask

  task automatic t_dir_redirect();
    upd(30, 1);
    check("R9 miss redirect", redirect, 1);
    check("R9 miss penalty", redirect_pen, 4);
    upd(30, 1);
    check("R9 agree no redirect", redirect, 0);
  endtask

  task automatic t_stack();
    do_push(32'hA0); do_push(32'hB0);
    do_pop(); check("R6 first pop", ret_target, 32'hB0);
    check("R6 valid", ret_valid, 1);
    step();   check("R6 held", ret_target, 32'hB0);
    do_pop(); check("R6 second pop", ret_target, 32'hA0);
    do_pop(); check("R8 empty valid", ret_valid, 0);
    check("R8 empty target", ret_target, 0);
    for (int i = 1; i <= 6; i++) do_push(32'(i * 16));
    for (int i = 6; i >= 3; i--) begin
      do_pop(); check("R7 newest kept", ret_target, 32'(i * 16));
    end
    do_pop(); check("R7 oldest dropped", ret_valid, 0);
  endtask

  task automatic t_push_pop();
    do_push(32'hC0);
    push = 1; push_addr = 32'hD0; pop = 1; step(); idle();
    check("R11 old top", ret_target, 32'hC0);
    do_pop(); check("R11 new top", ret_target, 32'hD0);
    do_pop(); check("R11 depth same", ret_valid, 0);
    push = 1; push_addr = 32'hE0; pop = 1; step(); idle();
    check("R11 empty pair invalid", ret_valid, 0);
    do_pop(); check("R11 empty becomes one", ret_target, 32'hE0);
  endtask

  task automatic t_ret_redirect();
    do_push(32'h100); do_pop();
    ret_chk_valid = 1; ret_chk_addr = 32'h100; step(); idle();
    check("R10 match no redirect", redirect, 0);
    ret_chk_valid = 1; ret_chk_addr = 32'h104; step(); idle();
    check("R10 mismatch redirect", redirect, 1);
    check("R10 mismatch penalty", redirect_pen, 5);
    do_pop();
    ret_chk_valid = 1; ret_chk_addr = 32'h100;
    up_valid = 1; up_idx = 11'd50; up_taken = 1;
    step(); idle();
    check("R10 unpredicted redirect", redirect, 1);
    check("R10 priority penalty", redirect_pen, 5);
  endtask

  initial begin
    idle(); rst = 1;
    t_reset();
    t_update();
    t_same_cycle();
    t_kinds();
    t_dir_redirect();
    t_stack();
    t_push_pop();
    t_ret_redirect();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule